// File: doc/BRIEF.md
# Operate Instruction Execute Unit

This unit carries out the three data-manipulation instructions of a small 16-bit teaching processor: addition, bitwise AND and bitwise complement. It holds eight 16-bit general registers and a condition register that marks the last written value as negative, zero or positive. Each qualified instruction word is decoded in the cycle it arrives. Its operands are read from the register file, or one operand is taken from a sign-extended 5-bit constant. The result is presented on the write outputs in that same cycle and is committed to the destination register at the next clock edge.

A second write path lets a load unit place a value in any register. That write updates the condition register by the same rule. When an operate instruction and a load both write in one cycle, the instruction's write wins and the load is dropped. Malformed operate encodings are reported on an illegal output and change no state. Instruction words with any other opcode belong to other units and are ignored.

Top module: `opx_exec_unit`

## Requirements
- R1: After a synchronous reset, every general register reads 0 and the condition flags read Z, so `flags` = 3'b010 (bit 2 N, bit 1 Z, bit 0 P).
- R2: When `instr_valid` is high and `instr` = {4'b0001, dst[11:9], src1[8:6], 1'b0, 2'b00, src2[2:0]}, the unit writes reg[src1] + reg[src2] (mod 2^16) to reg[dst].
- R3: For add and AND with bit 5 = 1, the second operand is bits [4:0] sign-extended to 16 bits.
- R4: Opcode 4'b0101 with the same field layout as R2 and R3 writes the bitwise AND of its two operands.
- R5: Opcode 4'b1001 with dst in [11:9], source in [8:6] and bits [5:0] = 6'b111111 writes the bitwise complement of reg[source].
- R6: After every register write, `flags` holds exactly one set bit: N when bit 15 of the written value is 1, Z when the value is 0, and P otherwise. With no write, `flags` keeps its value.
- R7: A valid complement whose bits [5:0] are not all ones raises `illegal` in the same cycle and writes nothing. So does a valid register-mode add or AND whose bits [4:3] are not 00.
- R8: A valid word with an opcode other than 0001, 0101 or 1001 makes no write and no `illegal`. So does any word while `instr_valid` is low.
- R9: Operands are read before the write of the same cycle, so an instruction that names its destination as a source uses the old value. A value written at one edge is visible to the instruction in the next cycle.
- R10: When `load_we` is high and no instruction writes, `load_data` is written to reg[`load_dst`] and the flags are updated as in R6.
- R11: When a legal instruction and `load_we` both want to write in one cycle, only the instruction's write takes place.
- R12: `wr_en`, `wr_dst` and `wr_data` show, in the same cycle, the write that the next clock edge will commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Qualifies `instr` this cycle |
| instr | input | 16 | Instruction word |
| load_we | input | 1 | Load path write request |
| load_dst | input | 3 | Load path destination register |
| load_data | input | 16 | Load path write value |
| illegal | output | 1 | Malformed operate encoding this cycle |
| wr_en | output | 1 | A register write commits at the next edge |
| wr_dst | output | 3 | Register that the write targets |
| wr_data | output | 16 | Value being written |
| flags | output | 3 | Condition register {N, Z, P} |

## Verification
`illegal` and the three write outputs are combinational from the instruction, the load request and the current register contents. The bench drives each stimulus on the falling edge and samples these outputs 1 ns later, in the same cycle. The register write and the flag update become visible one rising edge later, so the bench samples `flags` 1 ns after that edge, before the next stimulus. Register contents are brought out by adding zero to a register into itself, which shows the value on `wr_data`. The bench's model tracks the flag change that this read causes.

// File: rtl/opx_pkg.sv
package opx_pkg;

    localparam int WORD_W  = 16;
    localparam int REG_CNT = 8;
    localparam int REG_AW  = $clog2(REG_CNT);
    localparam int IMM_W   = 5;
    localparam int OPC_W   = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [REG_AW-1:0] ridx_t;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        FN_ADD  = 2'd0,
        FN_AND  = 2'd1,
        FN_INV  = 2'd2,
        FN_NONE = 2'd3
    } alu_fn_e;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;

    typedef struct packed {
        logic    exec;
        logic    bad;
        alu_fn_e fn;
        ridx_t   dst;
        ridx_t   src_a;
        ridx_t   src_b;
        logic    use_imm;
        word_t   imm;
    } dec_t;

    localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    function automatic word_t sext_imm(input logic [IMM_W-1:0] f);
        return {{(WORD_W-IMM_W){f[IMM_W-1]}}, f};
    endfunction

    function automatic cc_t cc_of(input word_t v);
        cc_t c;
        c.n = v[WORD_W-1];
        c.z = (v == '0);
        c.p = !v[WORD_W-1] && (v != '0);
        return c;
    endfunction

endpackage

// File: rtl/opx_decode.sv
module opx_decode
    import opx_pkg::*;
(
    input  logic  valid,
    input  word_t ins,
    output dec_t  dec
);

    logic [OPC_W-1:0] opc;
    logic             rr_pad_bad;
    logic             inv_tail_bad;

    assign opc          = ins[15:12];
    assign rr_pad_bad   = !ins[5] && (ins[4:3] != 2'b00);
    assign inv_tail_bad = (ins[5:0] != 6'b111111);

    always_comb begin
        dec         = '0;
        dec.fn      = FN_NONE;
        dec.dst     = ins[11:9];
        dec.src_a   = ins[8:6];
        dec.src_b   = ins[2:0];
        dec.use_imm = ins[5];
        dec.imm     = sext_imm(ins[IMM_W-1:0]);
        if (valid) begin
            if (opc == OPC_ADD) begin
                dec.exec = 1'b1;
                dec.fn   = FN_ADD;
                dec.bad  = rr_pad_bad;
            end else if (opc == OPC_AND) begin
                dec.exec = 1'b1;
                dec.fn   = FN_AND;
                dec.bad  = rr_pad_bad;
            end else if (opc == OPC_NOT) begin
                dec.exec    = 1'b1;
                dec.fn      = FN_INV;
                dec.bad     = inv_tail_bad;
                dec.use_imm = 1'b0;
            end
        end
    end

endmodule

// File: rtl/opx_alu.sv
module opx_alu
    import opx_pkg::*;
(
    input  alu_fn_e fn,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);

    always_comb begin
        unique case (fn)
            FN_ADD:  y = a + b;
            FN_AND:  y = a & b;
            FN_INV:  y = ~a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/opx_regfile.sv
module opx_regfile #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs[raddr[g]];
    end

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/opx_exec_unit.sv
module opx_exec_unit
    import opx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic [15:0] instr,
    input  logic        load_we,
    input  logic [2:0]  load_dst,
    input  logic [15:0] load_data,
    output logic        illegal,
    output logic        wr_en,
    output logic [2:0]  wr_dst,
    output logic [15:0] wr_data,
    output logic [2:0]  flags
);

    localparam int NRD = 2;

    dec_t                       dec;
    logic [NRD-1:0][REG_AW-1:0] rd_idx;
    logic [NRD-1:0][WORD_W-1:0] rd_val;
    word_t                      opnd_b;
    word_t                      alu_y;
    logic                       exec_we;
    cc_t                        cc_q;

    opx_decode u_dec (
        .valid (instr_valid),
        .ins   (instr),
        .dec   (dec)
    );

    assign rd_idx[0] = dec.src_a;
    assign rd_idx[1] = dec.src_b;

    opx_regfile #(
        .WIDTH (WORD_W),
        .DEPTH (REG_CNT),
        .NRD   (NRD)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_dst),
        .wdata (wr_data),
        .raddr (rd_idx),
        .rdata (rd_val)
    );

    assign opnd_b = dec.use_imm ? dec.imm : rd_val[1];

    opx_alu u_alu (
        .fn (dec.fn),
        .a  (rd_val[0]),
        .b  (opnd_b),
        .y  (alu_y)
    );

    assign exec_we = dec.exec && !dec.bad;
    assign illegal = dec.exec && dec.bad;
    assign wr_en   = exec_we || load_we;
    assign wr_dst  = exec_we ? dec.dst : load_dst;
    assign wr_data = exec_we ? alu_y : load_data;

    always_ff @(posedge clk) begin
        if (rst)        cc_q <= CC_RESET;
        else if (wr_en) cc_q <= cc_of(wr_data);
    end

    assign flags = {cc_q.n, cc_q.z, cc_q.p};

    assert_cc_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(flags) == 1);

    assert_cc_tracks_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> flags == cc_of($past(wr_data)));

    assert_illegal_no_exec_write_R7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wr_en || (load_we && wr_dst == load_dst && wr_data == load_data)));

    assert_idle_holds_cc_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flags));

endmodule

// File: tb/test_opx_exec_unit.sv
module test_opx_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        load_we = 1'b0;
    logic [2:0]  load_dst = '0;
    logic [15:0] load_data = '0;
    logic        illegal;
    logic        wr_en;
    logic [2:0]  wr_dst;
    logic [15:0] wr_data;
    logic [2:0]  flags;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] m_regs [8];
    logic [2:0]  m_flags;

    always #5 clk = ~clk;

    opx_exec_unit i_opx_exec_unit (
        .clk, .rst, .instr_valid, .instr, .load_we, .load_dst, .load_data,
        .illegal, .wr_en, .wr_dst, .wr_data, .flags
    );

    function automatic logic [2:0] nzp(input logic [15:0] v);
        return {v[15], v == 16'h0, !v[15] && v != 16'h0};
    endfunction

    function automatic logic [15:0] mk_rr(input logic [3:0] op, input int d, input int a, input int b);
        return {op, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction

    function automatic logic [15:0] mk_ri(input logic [3:0] op, input int d, input int a, input logic [4:0] k);
        return {op, 3'(d), 3'(a), 1'b1, k};
    endfunction

    function automatic logic [15:0] mk_inv(input int d, input int a);
        return {4'b1001, 3'(d), 3'(a), 6'b111111};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input logic v, input logic [15:0] ins, input logic lw,
                       input logic [2:0] ld, input logic [15:0] lv, input string tag);
        logic [3:0]  op;
        logic        ex, ok, ew, eill;
        logic [2:0]  ed;
        logic [15:0] eb, edat;
        op   = ins[15:12];
        ex   = v && (op == 4'b0001 || op == 4'b0101 || op == 4'b1001);
        ok   = (op == 4'b1001) ? (ins[5:0] == 6'h3f) : (ins[5] || ins[4:3] == 2'b00);
        eill = ex && !ok;
        eb   = ins[5] ? {{11{ins[4]}}, ins[4:0]} : m_regs[ins[2:0]];
        ew   = 1'b0; ed = '0; edat = '0;
        if (ex && ok) begin
            ew = 1'b1; ed = ins[11:9];
            if (op == 4'b0001)      edat = m_regs[ins[8:6]] + eb;
            else if (op == 4'b0101) edat = m_regs[ins[8:6]] & eb;
            else                    edat = ~m_regs[ins[8:6]];
        end else if (lw) begin
            ew = 1'b1; ed = ld; edat = lv;
        end
        @(negedge clk);
        instr_valid = v; instr = ins; load_we = lw; load_dst = ld; load_data = lv;
        #1;
        chk(illegal == eill, {tag, " illegal (R7)"}, 16'(illegal), 16'(eill));
        chk(wr_en == ew, {tag, " wr_en (R12)"}, 16'(wr_en), 16'(ew));
        if (ew) begin
            chk(wr_dst == ed, {tag, " wr_dst (R12)"}, 16'(wr_dst), 16'(ed));
            chk(wr_data == edat, {tag, " wr_data"}, wr_data, edat);
        end
        @(posedge clk);
        #1;
        if (ew) begin
            m_regs[ed] = edat;
            m_flags    = nzp(edat);
        end
        chk(flags == m_flags, {tag, " flags (R6)"}, 16'(flags), 16'(m_flags));
    endtask

    task automatic peek(input int k, input string tag);
        run(1'b1, mk_ri(4'b0001, k, k, 5'd0), 1'b0, '0, '0, tag);
    endtask

    task automatic seed();
        for (int k = 0; k < 8; k++) begin
            logic [15:0] s;
            case (k)
                0: s = 16'h0000;
                1: s = 16'h7fff;
                2: s = 16'h8000;
                3: s = 16'hffff;
                default: s = 16'(k * 16'h2d5b);
            endcase
            run(1'b0, '0, 1'b1, 3'(k), s, "R10 load");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) m_regs[k] = '0;
        m_flags = 3'b010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(flags == 3'b010, "R1 reset flags", 16'(flags), 16'h2);
        for (int k = 0; k < 8; k++) peek(k, "R1 reset reg");

        // R10 load path and R6 flags for edge values
        seed();
        for (int k = 0; k < 8; k++) peek(k, "R10 readback");

        // R2 register add, all register triples
        for (int d = 0; d < 8; d++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    if ((a + b) % 3 == 0) seed();
                    run(1'b1, mk_rr(4'b0001, d, a, b), 1'b0, '0, '0, "R2 add");
                end

        // R3 immediate add and AND, every constant
        seed();
        for (int a = 0; a < 8; a++)
            for (int k = 0; k < 32; k++) begin
                run(1'b1, mk_ri(4'b0001, (a + 1) % 8, a, 5'(k)), 1'b0, '0, '0, "R3 add imm");
                run(1'b1, mk_ri(4'b0101, (a + 2) % 8, a, 5'(k)), 1'b0, '0, '0, "R3 and imm");
                if (k % 8 == 7) seed();
            end

        // R4 register AND, all register triples
        for (int d = 0; d < 8; d++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    if (b == 0) seed();
                    run(1'b1, mk_rr(4'b0101, d, a, b), 1'b0, '0, '0, "R4 and");
                end

        // R5 complement, all pairs
        for (int d = 0; d < 8; d++)
            for (int a = 0; a < 8; a++)
                run(1'b1, mk_inv(d, a), 1'b0, '0, '0, "R5 not");

        // R7 malformed encodings, alone and with a load in the same cycle
        seed();
        for (int t = 0; t < 63; t++)
            run(1'b1, {4'b1001, 3'd1, 3'd2, 6'(t)}, 1'b0, '0, '0, "R7 bad not");
        for (int p = 1; p < 4; p++) begin
            run(1'b1, {4'b0001, 3'd4, 3'd5, 1'b0, 2'(p), 3'd6}, 1'b0, '0, '0, "R7 bad add");
            run(1'b1, {4'b0101, 3'd4, 3'd5, 1'b0, 2'(p), 3'd6}, 1'b0, '0, '0, "R7 bad and");
        end
        run(1'b1, {4'b1001, 3'd3, 3'd3, 6'b011111}, 1'b1, 3'd6, 16'h8001, "R7 bad with load");
        for (int k = 0; k < 8; k++) peek(k, "R7 regs intact");

        // R8 other opcodes and unqualified words
        for (int o = 0; o < 16; o++) begin
            if (o == 1 || o == 5 || o == 9) continue;
            run(1'b1, {4'(o), 12'hfff}, 1'b0, '0, '0, "R8 foreign op");
        end
        run(1'b0, mk_rr(4'b0001, 0, 1, 2), 1'b0, '0, '0, "R8 not valid");
        run(1'b0, mk_inv(3, 3), 1'b0, '0, '0, "R8 not valid");
        for (int k = 0; k < 8; k++) peek(k, "R8 regs intact");

        // R9 read before write, and back-to-back dependence
        seed();
        run(1'b1, mk_rr(4'b0001, 3, 3, 3), 1'b0, '0, '0, "R9 self add");
        run(1'b1, mk_rr(4'b0001, 0, 3, 1), 1'b0, '0, '0, "R9 next sees write");
        run(1'b0, '0, 1'b1, 3'd4, 16'h0040, "R9 load");
        run(1'b1, mk_ri(4'b0001, 5, 4, 5'h1f), 1'b0, '0, '0, "R9 uses loaded");

        // R11 instruction beats load
        run(1'b1, mk_ri(4'b0001, 1, 2, 5'd1), 1'b1, 3'd5, 16'h1234, "R11 conflict");
        run(1'b1, mk_rr(4'b0101, 6, 7, 7), 1'b1, 3'd6, 16'h0000, "R11 same dst");
        peek(5, "R11 load dropped");
        peek(6, "R11 exec kept");

        // R6 flags for negative, zero, positive results
        run(1'b0, '0, 1'b1, 3'd0, 16'h0001, "R6 load pos");
        run(1'b1, mk_ri(4'b0001, 0, 0, 5'h1e), 1'b0, '0, '0, "R6 neg");
        run(1'b1, mk_ri(4'b0001, 0, 0, 5'h01), 1'b0, '0, '0, "R6 zero");
        run(1'b1, mk_ri(4'b0001, 0, 0, 5'h0f), 1'b0, '0, '0, "R6 pos");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule